// File: doc/BRIEF.md
# Timer Capture/Compare Status Flags

This block keeps the event flags of a free-running timer. Two capture inputs, C and D, are synchronized and watched for the edge polarity that each channel selects. On a qualifying edge a channel either stores the present counter value in its capture register or, in buffer mode, stores nothing and only raises its flag. In buffer mode the pin serves as a general-purpose interrupt input. A third flag, compare A, rises whenever the counter equals the compare value.

Software reads the flags from one status register. It clears a flag by writing 0 to that flag's bit, but only after a read has returned the flag as 1. Each flag drives an interrupt request through its own enable. Counter clocking, compare output pins and buffer-register transfers belong to neighbouring blocks. Here the counter and the compare value arrive as plain inputs.

Top module: `tcf_top`

## Requirements
- R1: After a synchronous reset all flags, the interrupt requests, the status read data and both capture registers are 0.
- R2: A capture pin passes through a two-stage synchronizer. When its select bit is 1 a low-to-high transition sets the channel flag, and when the select bit is 0 a high-to-low transition sets it. The flag is set at the third rising clock edge after the pin changes.
- R3: With buffer mode off, the clock edge that sets a capture flag also loads that channel's capture register with the counter value present at that edge.
- R4: With buffer mode on, a detected edge sets the flag but leaves the capture register unchanged.
- R5: Each interrupt request is registered. It equals its flag ANDed with its enable, one clock later.
- R6: The compare-A flag is set at every clock edge at which the counter input equals the compare-A input.
- R7: Writing 1 to a flag bit never sets the flag and never changes it.
- R8: Writing 0 to a flag bit clears it only if a status read has returned that flag as 1 since it was set. Without such a read the write has no effect.
- R9: If a hardware set and a valid clear of the same flag fall on one clock edge, the flag stays 1.
- R10: The status register holds capture C in bit 5, capture D in bit 4 and compare A in bit 3. All other bits read 0. The read data is registered on the read strobe and shows the flag values from before that edge, and it holds between reads.
- R11: Once a flag has cleared, a new read returning 1 is needed before a later write of 0 can clear it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frc_val | input | CNT_W | Free-running counter value |
| cmp_a_val | input | CNT_W | Compare-A value |
| pin_c | input | 1 | Capture input C (asynchronous) |
| pin_d | input | 1 | Capture input D (asynchronous) |
| rise_sel_c | input | 1 | C edge select: 1 rising, 0 falling |
| rise_sel_d | input | 1 | D edge select: 1 rising, 0 falling |
| buf_mode_c | input | 1 | C buffer mode: flag only, no capture |
| buf_mode_d | input | 1 | D buffer mode: flag only, no capture |
| ie_c | input | 1 | Interrupt enable for capture C |
| ie_d | input | 1 | Interrupt enable for capture D |
| ie_a | input | 1 | Interrupt enable for compare A |
| stat_rd | input | 1 | Status read strobe |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 8 | Status write data |
| stat_rdata | output | 8 | Registered status read data |
| cap_c_val | output | CNT_W | Capture register C |
| cap_d_val | output | CNT_W | Capture register D |
| irq_c | output | 1 | Interrupt request, capture C |
| irq_d | output | 1 | Interrupt request, capture D |
| irq_a | output | 1 | Interrupt request, compare A |

## Verification
The assertions assume that the control inputs (edge select, buffer mode, enables), the counter and the compare value are already synchronous to clk. Only the two capture pins may change at arbitrary times. They also assume that a read and a write strobe in the same cycle act on the flag values from before that edge. The stimulus changes every input half a period away from the rising edge. It draws the counter and the compare value from a small range so that matches occur often, and it drives simultaneous read, write, set and clear cycles freely.

// File: rtl/tcf_pkg.sv
package tcf_pkg;
  localparam int STAT_W      = 8;
  localparam int NUM_CAP     = 2;   // channel 0 = C, channel 1 = D
  localparam int CAP_TOP_BIT = 5;   // channel i sits at bit CAP_TOP_BIT - i
  localparam int CMP_A_BIT   = 3;
  localparam logic [STAT_W-1:0] STAT_USED_MASK = 8'h38;
endpackage

// File: rtl/tcf_edge_det.sv
module tcf_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic rise_sel_i,
  output logic edge_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= cur;
    end
  end

  always_comb begin
    if (rise_sel_i) edge_o = cur & ~prev_q;
    else            edge_o = ~cur & prev_q;
  end

  // R2: an edge indication always reflects a change between two samples
  assert_edge_is_change_R2: assert property (@(posedge clk) disable iff (rst)
    edge_o |-> (cur != prev_q));
endmodule

// File: rtl/tcf_flag_cell.sv
module tcf_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic armed_q;
  logic clr_ok;
  logic flag_n;

  assign clr_ok = wr_i & ~wbit_i & armed_q;

  always_comb begin
    if (set_i)       flag_n = 1'b1;
    else if (clr_ok) flag_n = 1'b0;
    else             flag_n = flag_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_o <= flag_n;
      if (!flag_n)              armed_q <= 1'b0;
      else if (rd_i && flag_o)  armed_q <= 1'b1;
    end
  end

  assert_set_only_by_hw_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_o) |-> $past(set_i));
  assert_clear_needs_read_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_o) |-> $past(wr_i && !wbit_i && armed_q));
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);
  assert_rearm_after_clear_R11: assert property (@(posedge clk) disable iff (rst)
    !flag_o |-> !armed_q);
endmodule

// File: rtl/tcf_cap_reg.sv
module tcf_cap_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst)         q_o <= '0;
    else if (load_i) q_o <= din_i;
  end
endmodule

// File: rtl/tcf_top.sv
module tcf_top
  import tcf_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] frc_val,
  input  logic [CNT_W-1:0] cmp_a_val,
  input  logic             pin_c,
  input  logic             pin_d,
  input  logic             rise_sel_c,
  input  logic             rise_sel_d,
  input  logic             buf_mode_c,
  input  logic             buf_mode_d,
  input  logic             ie_c,
  input  logic             ie_d,
  input  logic             ie_a,
  input  logic             stat_rd,
  input  logic             stat_wr,
  input  logic [7:0]       stat_wdata,
  output logic [7:0]       stat_rdata,
  output logic [CNT_W-1:0] cap_c_val,
  output logic [CNT_W-1:0] cap_d_val,
  output logic             irq_c,
  output logic             irq_d,
  output logic             irq_a
);
  logic [NUM_CAP-1:0] pin_v, sel_v, buf_v, ie_v, edge_v, cflag_v;
  logic [CNT_W-1:0]   cap_q [NUM_CAP];
  logic               cmp_hit, aflag;
  logic [STAT_W-1:0]  stat_now;
  logic               unused_wbits;

  assign pin_v = {pin_d, pin_c};
  assign sel_v = {rise_sel_d, rise_sel_c};
  assign buf_v = {buf_mode_d, buf_mode_c};
  assign ie_v  = {ie_d, ie_c};
  assign unused_wbits = ^{stat_wdata[7:6], stat_wdata[2:0]};

  for (genvar ch = 0; ch < NUM_CAP; ch++) begin : g_cap
    tcf_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst(rst), .pin_i(pin_v[ch]), .rise_sel_i(sel_v[ch]),
      .edge_o(edge_v[ch]));

    tcf_cap_reg #(.W(CNT_W)) u_cap (
      .clk(clk), .rst(rst), .load_i(edge_v[ch] & ~buf_v[ch]),
      .din_i(frc_val), .q_o(cap_q[ch]));

    tcf_flag_cell u_flag (
      .clk(clk), .rst(rst), .set_i(edge_v[ch]), .rd_i(stat_rd),
      .wr_i(stat_wr), .wbit_i(stat_wdata[CAP_TOP_BIT-ch]),
      .flag_o(cflag_v[ch]));
  end

  assign cmp_hit = (frc_val == cmp_a_val);

  tcf_flag_cell u_flag_a (
    .clk(clk), .rst(rst), .set_i(cmp_hit), .rd_i(stat_rd),
    .wr_i(stat_wr), .wbit_i(stat_wdata[CMP_A_BIT]), .flag_o(aflag));

  always_comb begin
    stat_now = '0;
    for (int ch = 0; ch < NUM_CAP; ch++) stat_now[CAP_TOP_BIT-ch] = cflag_v[ch];
    stat_now[CMP_A_BIT] = aflag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_rdata <= '0;
      irq_c      <= 1'b0;
      irq_d      <= 1'b0;
      irq_a      <= 1'b0;
    end else begin
      if (stat_rd) stat_rdata <= stat_now;
      irq_c <= cflag_v[0] & ie_v[0];
      irq_d <= cflag_v[1] & ie_v[1];
      irq_a <= aflag & ie_a;
    end
  end

  assign cap_c_val = cap_q[0];
  assign cap_d_val = cap_q[1];

  assert_rsvd_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (stat_rdata & ~STAT_USED_MASK) == '0);
  assert_irq_follows_flag_R5: assert property (@(posedge clk) disable iff (rst)
    irq_c |-> $past(cflag_v[0] && ie_c));
  assert_buf_holds_R4: assert property (@(posedge clk) disable iff (rst)
    buf_mode_c |=> $stable(cap_c_val));
  assert_cap_load_R3: assert property (@(posedge clk) disable iff (rst)
    (edge_v[0] && !buf_mode_c) |=> (cap_c_val == $past(frc_val)));
  assert_cmp_sets_R6: assert property (@(posedge clk) disable iff (rst)
    cmp_hit |=> aflag);
endmodule

// File: tb/tcf_top_bench.sv
`timescale 1ns/1ps
module tcf_top_bench;
  localparam int W = 16;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] frc_val = '0, cmp_a_val = '1;
  logic pin_c = 0, pin_d = 0, rise_sel_c = 1, rise_sel_d = 0;
  logic buf_mode_c = 0, buf_mode_d = 0, ie_c = 0, ie_d = 0, ie_a = 0;
  logic stat_rd = 0, stat_wr = 0;
  logic [7:0] stat_wdata = '0;
  logic [7:0] stat_rdata;
  logic [W-1:0] cap_c_val, cap_d_val;
  logic irq_c, irq_d, irq_a;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  tcf_top #(.CNT_W(W)) u_tcf_top (.*);

  // reference model: index 0 = C, 1 = D, 2 = A
  logic [1:0] m_s1, m_s2, m_pv;
  logic [2:0] m_flag, m_arm, m_irq;
  logic [W-1:0] m_cap [2];
  logic [7:0] m_rd;

  function automatic logic edge_of(logic sel, logic cur, logic prv);
    return sel ? (cur & ~prv) : (~cur & prv);
  endfunction

  function automatic logic [7:0] stat_img(logic [2:0] f);
    return {2'b00, f[0], f[1], f[2], 3'b000};
  endfunction

  always @(posedge clk) begin : model
    logic [2:0] setv, wb, nf;
    logic e;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_pv = 0; m_flag = 0; m_arm = 0; m_irq = 0;
      m_cap[0] = 0; m_cap[1] = 0; m_rd = 0;
    end else begin
      e = edge_of(rise_sel_c, m_s2[0], m_pv[0]); setv[0] = e;
      if (e && !buf_mode_c) m_cap[0] = frc_val;
      e = edge_of(rise_sel_d, m_s2[1], m_pv[1]); setv[1] = e;
      if (e && !buf_mode_d) m_cap[1] = frc_val;
      setv[2] = (frc_val == cmp_a_val);
      wb = {stat_wdata[3], stat_wdata[4], stat_wdata[5]};
      if (stat_rd) m_rd = stat_img(m_flag);
      m_irq = m_flag & {ie_a, ie_d, ie_c};
      for (int i = 0; i < 3; i++) begin
        nf[i] = setv[i] ? 1'b1 : ((stat_wr && !wb[i] && m_arm[i]) ? 1'b0 : m_flag[i]);
        if (!nf[i]) m_arm[i] = 1'b0;
        else if (stat_rd && m_flag[i]) m_arm[i] = 1'b1;
      end
      m_flag = nf;
      m_pv = m_s2; m_s2 = m_s1; m_s1 = {pin_d, pin_c};
    end
  end

  task automatic expect_eq(string tag, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic check_model(string tag);
    expect_eq(tag, "rdata", 32'(stat_rdata), 32'(m_rd));
    expect_eq(tag, "cap_c", 32'(cap_c_val), 32'(m_cap[0]));
    expect_eq(tag, "cap_d", 32'(cap_d_val), 32'(m_cap[1]));
    expect_eq(tag, "irq", 32'({irq_a, irq_d, irq_c}), 32'(m_irq));
    expect_eq("R10", "reserved bits", 32'(stat_rdata & 8'hC7), 32'h0);
  endtask

  task automatic tick(string tag, int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      check_model(tag);
    end
  endtask

  task automatic rd_stat(string tag);
    stat_rd = 1; tick(tag); stat_rd = 0;
  endtask

  task automatic wr_stat(string tag, logic [7:0] d);
    stat_wr = 1; stat_wdata = d; tick(tag); stat_wr = 0; stat_wdata = 0;
  endtask

  initial begin : watchdog
    #1000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    expect_eq("R1", "rdata", 32'(stat_rdata), 0);
    expect_eq("R1", "irq", 32'({irq_a, irq_d, irq_c}), 0);
    expect_eq("R1", "cap_c", 32'(cap_c_val), 0);
    tick("R1");
    // R2/R3 rising edge on C captures counter
    frc_val = 16'h1234; pin_c = 1;
    tick("R2", 3);
    expect_eq("R3", "cap_c", 32'(cap_c_val), 32'h1234);
    rd_stat("R2");
    expect_eq("R2", "flag C", 32'(stat_rdata), 32'h20);
    // R7 writing ones changes nothing
    wr_stat("R7", 8'hFF); rd_stat("R7");
    expect_eq("R7", "after write 1", 32'(stat_rdata), 32'h20);
    // R8 falling edge on D, clear without prior read is ignored
    pin_d = 1; tick("R2", 4); pin_d = 0; tick("R2", 3);
    wr_stat("R8", 8'h00);   // clears C (armed), D unarmed
    rd_stat("R8");
    expect_eq("R8", "D kept, C cleared", 32'(stat_rdata), 32'h10);
    wr_stat("R8", 8'h00); rd_stat("R8");
    expect_eq("R8", "D cleared after read", 32'(stat_rdata), 32'h00);
    // R11 new D event needs a new read
    pin_d = 1; tick("R11", 4); pin_d = 0; tick("R11", 3);
    wr_stat("R11", 8'h00); rd_stat("R11");
    expect_eq("R11", "D not re-armed", 32'(stat_rdata), 32'h10);
    wr_stat("R11", 8'h00);
    // R4 buffer mode: flag only
    buf_mode_c = 1; frc_val = 16'h5555; pin_c = 0; tick("R4", 4);
    pin_c = 1; tick("R4", 3);
    rd_stat("R4");
    expect_eq("R4", "flag C", 32'(stat_rdata), 32'h20);
    expect_eq("R4", "cap_c held", 32'(cap_c_val), 32'h1234);
    // R5 interrupt gating
    tick("R5");
    expect_eq("R5", "irq_c off", 32'(irq_c), 0);
    ie_c = 1; tick("R5");
    expect_eq("R5", "irq_c on", 32'(irq_c), 1);
    ie_c = 0; wr_stat("R5", 8'h00); buf_mode_c = 0;
    // R6/R9 compare and set-wins
    frc_val = 16'h0042; cmp_a_val = 16'h0042; tick("R6");
    rd_stat("R6");
    expect_eq("R6", "flag A", 32'(stat_rdata), 32'h08);
    wr_stat("R9", 8'h00); rd_stat("R9");
    expect_eq("R9", "set wins", 32'(stat_rdata), 32'h08);
    frc_val = 16'h0000; wr_stat("R9", 8'h00); rd_stat("R9");
    expect_eq("R9", "cleared after match ends", 32'(stat_rdata), 32'h00);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      frc_val = W'($urandom_range(0, 7));
      cmp_a_val = W'($urandom_range(0, 7));
      if ($urandom_range(0, 5) == 0) pin_c = ~pin_c;
      if ($urandom_range(0, 5) == 0) pin_d = ~pin_d;
      if ($urandom_range(0, 40) == 0) begin
        rise_sel_c = 1'($urandom); rise_sel_d = 1'($urandom);
        buf_mode_c = 1'($urandom); buf_mode_d = 1'($urandom);
      end
      {ie_a, ie_d, ie_c} = 3'($urandom);
      stat_rd = ($urandom_range(0, 3) == 0);
      stat_wr = ($urandom_range(0, 4) == 0);
      stat_wdata = 8'($urandom);
      tick("R2 R3 R4 R5 R6 R8 R9 R10 R11");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule